// File: doc/BRIEF.md
# Selectable-Tap One-Bit Audio Delay Line

This block delays a one-bit delta-modulated audio stream by a selectable number of sample periods. Each sample strobe presents one bit. In normal running the block stores that bit in a circular buffer and reads back the bit stored a chosen number of samples earlier. The buffer holds six equal segments of `STEP_CELLS` cells. A three-bit code picks a tap of one to six segments. In slow rate mode only every second strobe is stored, so the same cells cover twice the time and every delay doubles.

A system mute starts a sweep over the whole buffer. The sweep writes one cell per clock with the quiet pattern, where a cell at address `a` holds `a mod 2`. Tap and rate settings are sampled only while the block is not running, which means during the sweep or while mute is held. Changes made at any other time are ignored. After mute is released and the sweep is done, storage starts again from address 0. The valid flag stays low until the tap has been filled with real samples. Until then the output plays back the cleared cells, which alternate between 0 and 1, so no stale audio reaches the output.

Top module: `dly_line`

## Requirements
- R1: While `rst` is high at a clock edge, `delay_bit` and `delay_valid` go to 0 and a full buffer sweep begins.
- R2: With rate fast and code `c` in 0..5, the tap length is `L = (c+1)*STEP_CELLS` stored samples. An accepted strobe at edge `n` updates `delay_bit` at edge `n+1` to the bit accepted `L` samples earlier.
- R3: In slow mode, the first strobe while running is stored, then every second strobe after it. Skipped strobes store nothing, so delays in strobe periods double.
- R4: Codes 6 and 7 select the longest tap, `6*STEP_CELLS`.
- R5: The longest tap spans the whole buffer. The cell is read before it is overwritten, so the output is the bit accepted exactly `DEPTH` samples earlier.
- R6: A clock edge with `mute` high while running starts a sweep of `DEPTH` clocks. The sweep writes `a mod 2` into cell `a` for a = 0..DEPTH-1 in order, and it runs to the end even if `mute` falls first. Running resumes at the first edge after the sweep with `mute` low.
- R7: While not running, or on the edge where `mute` is high, a strobe stores nothing. It inverts `delay_bit` one edge later and drives `delay_valid` to 0.
- R8: Code and rate are sampled on every edge where the block is not running. While running, their inputs have no effect.
- R9: After a sweep, `delay_valid` is 0 for accepted samples until at least `L` samples have been stored. It is 1 from then on.
- R10: Before the tap fills, accepted samples output the swept pattern, which alternates between 0 and 1 from one accepted sample to the next.
- R11: In slow mode a skipped strobe leaves `delay_bit` and `delay_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-clock sample strobe |
| sample_bit | input | 1 | Incoming one-bit sample |
| delay_code | input | 3 | Tap select code |
| slow_mode | input | 1 | 1 = slow rate (every second strobe stored) |
| mute | input | 1 | System mute; starts a buffer sweep |
| delay_bit | output | 1 | Delayed sample bit |
| delay_valid | output | 1 | Output carries real delayed audio |

## Verification
On every cycle the assertions check the following. A mute while running always enters the sweep, and the sweep address stays inside the buffer. Nothing is stored outside the running state, and in slow mode no two consecutive strobes are both stored. The settings stay frozen while running, the fill count never exceeds the buffer, and a strobe while idle always clears the valid flag. The per-clock reference model in the bench covers what needs history: that the bit heard is the one stored exactly one tap earlier at every code, rate and strobe spacing, that the full-depth tap reads before writing, that the swept pattern plays before the tap fills, and that a sweep finishes after an early mute release.

// File: rtl/dly_pkg.sv
package dly_pkg;

  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2
  } dly_state_e;

  localparam int unsigned MAX_STEP = 6;

  // Tap code to segment count; reserved codes fall back to the longest tap.
  function automatic logic [2:0] code_to_step(input logic [2:0] code);
    if (code > 3'd5) return 3'd6;
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int unsigned DEPTH      = 1536,
  parameter int unsigned STEP_CELLS = 256,
  parameter int unsigned AW         = $clog2(DEPTH),
  parameter int unsigned FW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic          sample_bit,
  input  logic [2:0]    delay_code,
  input  logic          slow_mode,
  input  logic          mute,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_wdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          tap_full,
  output logic          idle_tick
);

  localparam int unsigned SW = $clog2(2 * DEPTH);

  dly_state_e    state;
  logic [AW-1:0] sweep_addr;
  logic [AW-1:0] wr_ptr;
  logic [FW-1:0] fill;
  logic          phase;
  logic [2:0]    cfg_step;
  logic          cfg_slow;

  logic          running;
  logic          accept;
  logic [FW-1:0] tap_len;
  logic [SW-1:0] back_sum;

  always_comb begin
    running   = (state == ST_RUN) && !mute;
    accept    = running && sample_en && (!cfg_slow || !phase);
    idle_tick = sample_en && !running;
    tap_len   = FW'(cfg_step) * FW'(STEP_CELLS);
    back_sum  = SW'(wr_ptr) + SW'(DEPTH) - SW'(tap_len);
    mem_raddr = (back_sum >= SW'(DEPTH)) ? AW'(back_sum - SW'(DEPTH)) : AW'(back_sum);
    mem_re    = accept;
    tap_full  = (fill >= tap_len);
    if (state == ST_SWEEP) begin
      mem_we    = 1'b1;
      mem_waddr = sweep_addr;
      mem_wdata = sweep_addr[0];
    end else begin
      mem_we    = accept;
      mem_waddr = wr_ptr;
      mem_wdata = sample_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SWEEP;
      sweep_addr <= '0;
      wr_ptr     <= '0;
      fill       <= '0;
      phase      <= 1'b0;
      cfg_step   <= 3'd1;
      cfg_slow   <= 1'b0;
    end else begin
      if (state != ST_RUN) begin
        cfg_step <= code_to_step(delay_code);
        cfg_slow <= slow_mode;
      end
      unique case (state)
        ST_SWEEP: begin
          if (sweep_addr == AW'(DEPTH - 1)) state <= ST_HOLD;
          else sweep_addr <= sweep_addr + 1'b1;
        end
        ST_HOLD: begin
          if (!mute) state <= ST_RUN;
        end
        ST_RUN: begin
          if (mute) begin
            state      <= ST_SWEEP;
            sweep_addr <= '0;
            wr_ptr     <= '0;
            fill       <= '0;
            phase      <= 1'b0;
          end else if (sample_en) begin
            if (cfg_slow) phase <= ~phase;
            if (accept) begin
              wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
              if (fill != FW'(DEPTH)) fill <= fill + 1'b1;
            end
          end
        end
        default: state <= ST_SWEEP;
      endcase
    end
  end

  assert_mute_starts_sweep_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && mute) |=> (state == ST_SWEEP));

  assert_sweep_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWEEP) |-> (sweep_addr < AW'(DEPTH)));

  assert_no_store_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |-> !mem_re);

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state == ST_RUN)) |-> ($stable(cfg_step) && $stable(cfg_slow)));

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(DEPTH));

  assert_slow_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_slow && state == ST_RUN && $past(state == ST_RUN) && $past(mem_re) && sample_en)
      |-> !mem_re);

endmodule

// File: rtl/dly_mem.sv
module dly_mem #(
  parameter int unsigned DEPTH = 1536,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic cells [DEPTH];

  // Read-first: a same-address write lands after the old value is captured.
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/dly_out.sv
module dly_out (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic full,
  input  logic idle,
  input  logic rdata,
  output logic delay_bit,
  output logic delay_valid
);

  logic take_q;
  logic full_q;
  logic idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q      <= 1'b0;
      full_q      <= 1'b0;
      idle_q      <= 1'b0;
      delay_bit   <= 1'b0;
      delay_valid <= 1'b0;
    end else begin
      take_q <= take;
      full_q <= full;
      idle_q <= idle;
      if (take_q) begin
        delay_bit   <= rdata;
        delay_valid <= full_q;
      end else if (idle_q) begin
        delay_bit   <= ~delay_bit;
        delay_valid <= 1'b0;
      end
    end
  end

  assert_idle_invalid_R7: assert property (@(posedge clk) disable iff (rst)
    (idle && !take) |=> ##1 !delay_valid);

endmodule

// File: rtl/dly_line.sv
module dly_line
  import dly_pkg::*;
#(
  parameter int unsigned STEP_CELLS = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_en,
  input  logic       sample_bit,
  input  logic [2:0] delay_code,
  input  logic       slow_mode,
  input  logic       mute,
  output logic       delay_bit,
  output logic       delay_valid
);

  localparam int unsigned DEPTH = MAX_STEP * STEP_CELLS;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned FW    = $clog2(DEPTH + 1);

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic          mem_wdata;
  logic          mem_re;
  logic [AW-1:0] mem_raddr;
  logic          mem_rdata;
  logic          tap_full;
  logic          idle_tick;

  dly_ctrl #(
    .DEPTH      (DEPTH),
    .STEP_CELLS (STEP_CELLS),
    .AW         (AW),
    .FW         (FW)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .sample_en  (sample_en),
    .sample_bit (sample_bit),
    .delay_code (delay_code),
    .slow_mode  (slow_mode),
    .mute       (mute),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re),
    .mem_raddr  (mem_raddr),
    .tap_full   (tap_full),
    .idle_tick  (idle_tick)
  );

  dly_mem #(
    .DEPTH (DEPTH),
    .AW    (AW)
  ) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  dly_out out_i (
    .clk         (clk),
    .rst         (rst),
    .take        (mem_re),
    .full        (tap_full),
    .idle        (idle_tick),
    .rdata       (mem_rdata),
    .delay_bit   (delay_bit),
    .delay_valid (delay_valid)
  );

endmodule

// File: tb/dly_line_tb.sv
module dly_line_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 256;
  localparam int DEPTH      = 6 * STEP;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic       sample_bit = 1'b0;
  logic [2:0] delay_code = 3'd0;
  logic       slow_mode = 1'b0;
  logic       mute = 1'b0;
  logic       delay_bit;
  logic       delay_valid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dly_line #(.STEP_CELLS(STEP)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .sample_en   (sample_en),
    .sample_bit  (sample_bit),
    .delay_code  (delay_code),
    .slow_mode   (slow_mode),
    .mute        (mute),
    .delay_bit   (delay_bit),
    .delay_valid (delay_valid)
  );

  // Behavioural reference: 0 = sweeping, 1 = waiting for unmute, 2 = running.
  bit     m_mem [DEPTH];
  int     m_mode, m_sweep, m_ptr, m_fill, m_step;
  bit     m_ph, m_slow, m_out, m_val, p_take, p_idle, p_bit, p_full;
  int     checks = 0, fails = 0, cycles = 0;
  bit     started = 0, done = 0;
  string  tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      m_mode = 0; m_sweep = 0; m_ptr = 0; m_fill = 0; m_ph = 0;
      m_step = 1; m_slow = 0; m_out = 0; m_val = 0; p_take = 0; p_idle = 0;
    end else begin
      bit run, take;
      int len, ra;
      if (p_take) begin m_out = p_bit; m_val = p_full; end
      else if (p_idle) begin m_out = !m_out; m_val = 0; end
      run  = (m_mode == 2) && !mute;
      take = run && sample_en && (!m_slow || !m_ph);
      p_take = take;
      p_idle = sample_en && !run;
      len = m_step * STEP;
      if (take) begin
        ra = (m_ptr - len + DEPTH) % DEPTH;
        p_bit  = m_mem[ra];
        p_full = (m_fill >= len);
        m_mem[m_ptr] = sample_bit;
        m_ptr = (m_ptr + 1) % DEPTH;
        if (m_fill < DEPTH) m_fill++;
      end
      if (run && sample_en && m_slow) m_ph = !m_ph;
      if (m_mode != 2) begin
        m_step = (delay_code > 5) ? 6 : delay_code + 1;
        m_slow = slow_mode;
      end
      case (m_mode)
        0: begin
          m_mem[m_sweep] = m_sweep[0];
          if (m_sweep == DEPTH - 1) m_mode = 1; else m_sweep++;
        end
        1: if (!mute) m_mode = 2;
        default: if (mute) begin
          m_mode = 0; m_sweep = 0; m_ptr = 0; m_fill = 0; m_ph = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (delay_bit !== m_out || delay_valid !== m_val) begin
        fails++;
        $display("FAIL %s cycle %0d: bit/valid actual %b/%b expected %b/%b",
                 tag, cycles, delay_bit, delay_valid, m_out, m_val);
      end
    end
  end

  task automatic drive(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sample_en  = (i % period) == 0;
      sample_bit = lfsr[0];
    end
  endtask

  task automatic mute_pulse(input int len, input logic [2:0] code, input logic slow);
    @(negedge clk);
    mute = 1'b1; delay_code = code; slow_mode = slow;
    drive(len, 1);
    @(negedge clk);
    mute = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles, expected at most 190000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R7: strobes during the power-up sweep toggle the output, never stored
    tag = "R7";
    drive(1700, 4);
    // R2 and R9 and R10: fast mode, one-segment tap, strobe every clock
    tag = "R2/R9/R10";
    drive(1000, 1);
    // R8: setting changes while running are ignored
    tag = "R8";
    delay_code = 3'd3; slow_mode = 1'b1;
    drive(500, 1);
    // R6: mute released early, sweep still completes; then three-segment tap
    tag = "R6";
    mute_pulse(3, 3'd2, 1'b0);
    drive(1700, 2);
    tag = "R2";
    drive(2200, 2);
    // R5: longest tap equals the whole buffer, read before write
    tag = "R5";
    mute_pulse(1600, 3'd5, 1'b0);
    drive(3800, 1);
    // R4, R3, R11: reserved code in slow mode
    tag = "R4/R3/R11";
    mute_pulse(1600, 3'd7, 1'b1);
    drive(7000, 1);
    // R3: slow mode with odd strobe spacing, one-segment tap
    tag = "R3";
    mute_pulse(1600, 3'd0, 1'b1);
    drive(2400, 3);
    // R7: strobes while mute held
    tag = "R7";
    @(negedge clk);
    mute = 1'b1;
    drive(300, 2);
    mute = 1'b0;
    drive(1800, 1);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule